// File: doc/BRIEF.md
# Grouped-Vector Interrupt Controller

This block gathers event sources for a small 4-bit microcontroller and turns them into one interrupt request with a vector. It has three clock-timer taps (32, 8 and 2 Hz), two stopwatch taps (10 and 1 Hz), a bank of key inputs, one port input and a serial interface. Every event latches a pending flag, and each flag has its own enable bit. Software writes the enable registers and reads them back over a 4-bit I/O bus. Reading a flag register returns the pending flags and clears them in the same access.

The vector is not a single winner picked by priority. A pending serial event always produces step 8. Otherwise the step carries one bit for each active group: clock in bit 0, stopwatch in bit 1, input in bit 2. Steps 1 to 7 therefore show exactly which groups are pending. When the CPU's interrupt enable is high, the request starts a fixed 12-cycle entry period. The period ends with a strobe that hands the vector step to the program counter, which loads it on page 1.

Top module: `irq_combiner`

## Requirements
- R1: After reset, every enable bit and every pending flag is 0, every register reads 0, and `irq_req` is 0.
- R2: Enable registers, with 1 meaning enabled: 0xE8 bits 3..0 are keys 3..0; 0xE9 bit 2 is the port, bit 1 is the serial-pin direction (driven on `sio_dir`) and bit 0 is the serial source; 0xEA bit 1 is stopwatch 1 Hz and bit 0 is stopwatch 10 Hz; 0xEB bit 2 is clock 2 Hz, bit 1 is clock 8 Hz and bit 0 is clock 32 Hz. Each reads back what was written.
- R3: Unused register bits always read 0. Any address that is not a register reads 0.
- R4: Flag registers are read-only, with 1 meaning pending: 0xEC bit 0 is serial; 0xED bit 1 is port and bit 0 is the key group; 0xEE and 0xEF use the same bit layout as 0xEA and 0xEB. An event pulse sets its flag whatever its enable bit.
- R5: Reading a flag register clears that register's flags on the same clock edge.
- R6: If an event pulse arrives in the same cycle as a read that clears its flag, the flag stays set.
- R7: The key group flag is set only when an enabled key rises from 0 to 1. Disabled keys and falling edges do not set it.
- R8: A group is active when one of its flags is set and that flag is enabled. The key flag counts as active while any key is enabled.
- R9: `pend_vec` is 8 when the serial group is active. Otherwise it is {0, input, stopwatch, clock}, and it is 0 when no group is active.
- R10: `irq_req` is high only when some group is active, `cpu_ie` is 1 and no entry period is running.
- R11: The edge on which `irq_req` is high starts an entry period that lasts exactly 12 cycles of `entry_busy`. `vec_load` pulses in the last of those cycles, and `vec_step` carries the vector captured when the period started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O register address |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (clears the flags it reads) |
| io_wdata | input | 4 | Write data |
| io_rdata | output | 4 | Read data, combinational |
| key_in | input | KEY_W | Key input levels |
| port_evt | input | 1 | Port input event pulse |
| sio_evt | input | 1 | Serial interface event pulse |
| ct_evt | input | 3 | Clock timer pulses: bit 0 = 32 Hz, bit 1 = 8 Hz, bit 2 = 2 Hz |
| sw_evt | input | 2 | Stopwatch pulses: bit 0 = 10 Hz, bit 1 = 1 Hz |
| cpu_ie | input | 1 | CPU interrupt enable |
| sio_dir | output | 1 | Serial-pin direction control bit |
| pend_vec | output | 4 | Current combined vector step |
| irq_req | output | 1 | Interrupt request |
| entry_busy | output | 1 | Entry period in progress |
| vec_load | output | 1 | Vector-load strobe |
| vec_step | output | 4 | Vector step loaded by the strobe |

## Verification
The combiner is driven with all 128 combinations of event pulses on seven sources (clock, stopwatch, port, serial) with every source enabled. This shows that each group's bit is independent of the others and that serial overrides them all. A second sweep fires every source and walks all 128 enable patterns, which separates "flag set" from "group active". Each step reads the flag registers back, which exercises the clear-on-read path. Further tests cover: each key's rising and falling edges under a single-key enable, a read colliding with a new event, and one complete entry period timed cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DW = 4;
   localparam int AW = 8;
   localparam logic [AW-1:0] A_EN_KEY  = 8'hE8;
   localparam logic [AW-1:0] A_EN_MISC = 8'hE9;
   localparam logic [AW-1:0] A_EN_SW   = 8'hEA;
   localparam logic [AW-1:0] A_EN_CT   = 8'hEB;
   localparam logic [AW-1:0] A_FL_SIO  = 8'hEC;
   localparam logic [AW-1:0] A_FL_INP  = 8'hED;
   localparam logic [AW-1:0] A_FL_SW   = 8'hEE;
   localparam logic [AW-1:0] A_FL_CT   = 8'hEF;
   localparam logic [3:0]    STEP_SIO  = 4'h8;

   typedef struct packed {
      logic sio;
      logic inp;
      logic sw;
      logic ct;
   } grp_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);
   initial assert (W >= 1 && W <= 4) else $error("flag bank width out of range");

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;
         else if (clr_i)    q_o[i] <= 1'b0;
      end
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (q_o == '0));
endmodule

// File: rtl/irq_vector_combine.sv
module irq_vector_combine
   import irq_pkg::*;
(
   input  grp_t       grp_i,
   output logic [3:0] vec_o,
   output logic       any_o
);
   always_comb begin
      any_o = |grp_i;
      if (grp_i.sio) vec_o = STEP_SIO;
      else           vec_o = {1'b0, grp_i.inp, grp_i.sw, grp_i.ct};
   end

   // R9
   always_comb vec_range_chk: assert (!any_o || (vec_o != 4'h0 && vec_o <= STEP_SIO));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int CYCLES = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [3:0] vec_i,
   output logic       busy_o,
   output logic       load_o,
   output logic [3:0] step_o
);
   localparam int CW = $clog2(CYCLES);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   initial assert (CYCLES >= 2) else $error("entry length too short");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
         step_o <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt    <= '0;
         step_o <= vec_i;
      end else if (busy_o) begin
         if (cnt == LAST) busy_o <= 1'b0;
         cnt <= cnt + 1'b1;
      end
   end

   assign load_o = busy_o && (cnt == LAST);

   // R11
   load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> busy_o);
   // R11
   load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !busy_o);
   // R11
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(step_o));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irq_pkg::*;
#(
   parameter int KEY_W        = 4,
   parameter bit KEY_RISE     = 1'b1,
   parameter int ENTRY_CYCLES = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       io_addr,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [3:0]       io_wdata,
   output logic [3:0]       io_rdata,
   input  logic [KEY_W-1:0] key_in,
   input  logic             port_evt,
   input  logic             sio_evt,
   input  logic [2:0]       ct_evt,
   input  logic [1:0]       sw_evt,
   input  logic             cpu_ie,
   output logic             sio_dir,
   output logic [3:0]       pend_vec,
   output logic             irq_req,
   output logic             entry_busy,
   output logic             vec_load,
   output logic [3:0]       vec_step
);
   initial assert (KEY_W >= 1 && KEY_W <= DW) else $error("KEY_W must fit one register");

   // enable registers
   logic [KEY_W-1:0] en_key;
   logic             en_port, en_sio;
   logic [1:0]       en_sw;
   logic [2:0]       en_ct;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_key  <= '0;
         en_port <= 1'b0;
         sio_dir <= 1'b0;
         en_sio  <= 1'b0;
         en_sw   <= '0;
         en_ct   <= '0;
      end else if (io_wr) begin
         case (io_addr)
            A_EN_KEY:  en_key <= io_wdata[KEY_W-1:0];
            A_EN_MISC: {en_port, sio_dir, en_sio} <= io_wdata[2:0];
            A_EN_SW:   en_sw  <= io_wdata[1:0];
            A_EN_CT:   en_ct  <= io_wdata[2:0];
            default: ;
         endcase
      end
   end

   // key edge detection, variant chosen by active level
   logic [KEY_W-1:0] key_q, key_edge;
   always_ff @(posedge clk) begin
      if (!rst_n) key_q <= {KEY_W{~KEY_RISE}};
      else        key_q <= key_in;
   end
   if (KEY_RISE) begin : g_rise
      assign key_edge = key_in & ~key_q;
   end else begin : g_fall
      assign key_edge = ~key_in & key_q;
   end

   // flag banks
   logic       rd_sio, rd_inp, rd_sw, rd_ct;
   logic       fl_sio;
   logic [1:0] fl_inp, fl_sw;
   logic [2:0] fl_ct;

   assign rd_sio = io_rd && (io_addr == A_FL_SIO);
   assign rd_inp = io_rd && (io_addr == A_FL_INP);
   assign rd_sw  = io_rd && (io_addr == A_FL_SW);
   assign rd_ct  = io_rd && (io_addr == A_FL_CT);

   irq_flag_bank #(.W(1)) u_fl_sio (.clk(clk), .rst_n(rst_n), .set_i(sio_evt),
      .clr_i(rd_sio), .q_o(fl_sio));
   irq_flag_bank #(.W(2)) u_fl_inp (.clk(clk), .rst_n(rst_n),
      .set_i({port_evt, |(key_edge & en_key)}), .clr_i(rd_inp), .q_o(fl_inp));
   irq_flag_bank #(.W(2)) u_fl_sw (.clk(clk), .rst_n(rst_n), .set_i(sw_evt),
      .clr_i(rd_sw), .q_o(fl_sw));
   irq_flag_bank #(.W(3)) u_fl_ct (.clk(clk), .rst_n(rst_n), .set_i(ct_evt),
      .clr_i(rd_ct), .q_o(fl_ct));

   // read mux
   always_comb begin
      io_rdata = '0;
      if (io_rd) begin
         case (io_addr)
            A_EN_KEY:  io_rdata = DW'(en_key);
            A_EN_MISC: io_rdata = {1'b0, en_port, sio_dir, en_sio};
            A_EN_SW:   io_rdata = {2'b0, en_sw};
            A_EN_CT:   io_rdata = {1'b0, en_ct};
            A_FL_SIO:  io_rdata = {3'b0, fl_sio};
            A_FL_INP:  io_rdata = {2'b0, fl_inp};
            A_FL_SW:   io_rdata = {2'b0, fl_sw};
            A_FL_CT:   io_rdata = {1'b0, fl_ct};
            default:   io_rdata = '0;
         endcase
      end
   end

   // group activity and vector
   grp_t grp;
   logic any_act;
   assign grp.sio = fl_sio & en_sio;
   assign grp.inp = (fl_inp[1] & en_port) | (fl_inp[0] & (|en_key));
   assign grp.sw  = |(fl_sw & en_sw);
   assign grp.ct  = |(fl_ct & en_ct);

   irq_vector_combine u_comb (.grp_i(grp), .vec_o(pend_vec), .any_o(any_act));

   assign irq_req = any_act & cpu_ie & ~entry_busy;

   irq_entry_seq #(.CYCLES(ENTRY_CYCLES)) u_entry (.clk(clk), .rst_n(rst_n),
      .start_i(irq_req), .vec_i(pend_vec), .busy_o(entry_busy), .load_o(vec_load),
      .step_o(vec_step));

   // R10
   no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_busy |-> !irq_req);
   // R11
   req_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> (entry_busy && vec_step == $past(pend_vec)));
   // R3
   unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr[7:4] == 4'hE && io_addr[3:0] != 4'h8) |-> !io_rdata[3]);
endmodule

// File: tb/sim_irq_combiner.sv
`timescale 1ns/1ps
module sim_irq_combiner;
   logic       clk = 0, rst_n = 0;
   logic [7:0] io_addr = 0;
   logic       io_wr = 0, io_rd = 0;
   logic [3:0] io_wdata = 0, io_rdata;
   logic [3:0] key_in = 0;
   logic       port_evt = 0, sio_evt = 0, cpu_ie = 0;
   logic [2:0] ct_evt = 0;
   logic [1:0] sw_evt = 0;
   logic       sio_dir, irq_req, entry_busy, vec_load;
   logic [3:0] pend_vec, vec_step;
   int checks = 0, fails = 0;
   logic [3:0] rv;

   always #2 clk = ~clk;

   irq_combiner u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .key_in(key_in),
      .port_evt(port_evt), .sio_evt(sio_evt), .ct_evt(ct_evt), .sw_evt(sw_evt),
      .cpu_ie(cpu_ie), .sio_dir(sio_dir), .pend_vec(pend_vec), .irq_req(irq_req),
      .entry_busy(entry_busy), .vec_load(vec_load), .vec_step(vec_step));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [3:0] d);
      io_addr = a; io_wdata = d; io_wr = 1;
      @(posedge clk); @(negedge clk);
      io_wr = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [3:0] d);
      io_addr = a; io_rd = 1;
      #1 d = io_rdata;
      @(posedge clk); @(negedge clk);
      io_rd = 0;
   endtask

   task automatic fire(logic [2:0] c, logic [1:0] s, logic p, logic si);
      ct_evt = c; sw_evt = s; port_evt = p; sio_evt = si;
      @(posedge clk); @(negedge clk);
      ct_evt = 0; sw_evt = 0; port_evt = 0; sio_evt = 0;
   endtask

   task automatic clear_all();
      logic [3:0] d;
      rd(8'hEC, d); rd(8'hED, d); rd(8'hEE, d); rd(8'hEF, d);
   endtask

   function automatic logic [3:0] exp_vec(logic [6:0] ev, logic [6:0] en);
      logic c, s, i, si;
      c  = |(ev[2:0] & en[2:0]);
      s  = |(ev[4:3] & en[4:3]);
      i  = ev[5] & en[5];
      si = ev[6] & en[6];
      return si ? 4'h8 : {1'b0, i, s, c};
   endfunction

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int a = 8'hE8; a <= 8'hEF; a++) begin
         rd(8'(a), rv); chk("R1 reset read", rv, 0);
      end
      chk("R1 irq_req", irq_req, 0);
      chk("R1 sio_dir", sio_dir, 0);

      // R2 / R3 write-read with unused bits
      wr(8'hE8, 4'hF); rd(8'hE8, rv); chk("R2 key enables", rv, 4'hF);
      wr(8'hE9, 4'hF); rd(8'hE9, rv); chk("R3 misc unused", rv, 4'h7);
      chk("R2 sio_dir", sio_dir, 1);
      wr(8'hEA, 4'hF); rd(8'hEA, rv); chk("R3 sw unused", rv, 4'h3);
      wr(8'hEB, 4'hF); rd(8'hEB, rv); chk("R3 ct unused", rv, 4'h7);
      rd(8'hE7, rv); chk("R3 unmapped", rv, 0);
      wr(8'hE8, 4'h0);

      // R4 R5 R9 sweep of event patterns, all enabled
      for (int p = 0; p < 128; p++) begin
         fire(p[2:0], p[4:3], p[5], p[6]);
         chk("R9 vector sweep", pend_vec, exp_vec(7'(p), 7'h7F));
         rd(8'hEF, rv); chk("R4 ct flags", rv, {1'b0, 3'(p[2:0])});
         rd(8'hEE, rv); chk("R4 sw flags", rv, {2'b0, 2'(p[4:3])});
         rd(8'hED, rv); chk("R4 inp flags", rv, {2'b0, p[5], 1'b0});
         rd(8'hEC, rv); chk("R4 sio flag", rv, {3'b0, p[6]});
         rd(8'hEF, rv); chk("R5 cleared", rv, 0);
         chk("R5 vector idle", pend_vec, 0);
      end

      // R8 enable sweep, all sources fired
      for (int m = 0; m < 128; m++) begin
         wr(8'hEB, {1'b0, 3'(m[2:0])});
         wr(8'hEA, {2'b0, 2'(m[4:3])});
         wr(8'hE9, {1'b0, m[5], 1'b0, m[6]});
         fire(3'h7, 2'h3, 1, 1);
         chk("R8 enable sweep", pend_vec, exp_vec(7'h7F, 7'(m)));
         cpu_ie = 0; #1;
         chk("R10 gated by ie", irq_req, 0);
         clear_all();
      end
      wr(8'hE9, 4'h0); wr(8'hEA, 4'h0); wr(8'hEB, 4'h0);

      // R7 key edges, only key 2 enabled
      wr(8'hE8, 4'h4);
      key_in = 4'b0010; @(negedge clk); @(negedge clk);
      rd(8'hED, rv); chk("R7 disabled key", rv, 0);
      key_in = 4'b0110; @(negedge clk);
      chk("R8 key group", pend_vec, 4'h4);
      rd(8'hED, rv); chk("R7 enabled rise", rv, 1);
      key_in = 4'b0000; @(negedge clk); @(negedge clk);
      rd(8'hED, rv); chk("R7 falling edge", rv, 0);
      wr(8'hE8, 4'h0);

      // R6 collision of read and new event
      fire(3'h1, 0, 0, 0);
      io_addr = 8'hEF; io_rd = 1; ct_evt = 3'h2;
      #1 rv = io_rdata;
      @(posedge clk); @(negedge clk);
      io_rd = 0; ct_evt = 0;
      chk("R6 read value", rv, 1);
      rd(8'hEF, rv); chk("R6 kept flag", rv, 2);

      // R10 R11 entry period
      wr(8'hEB, 4'h1); wr(8'hEA, 4'h1);
      fire(3'h1, 2'h1, 0, 0);
      chk("R10 off without ie", irq_req, 0);
      cpu_ie = 1; #1;
      chk("R10 request", irq_req, 1);
      begin
         int n = 0;
         bit seen = 0;
         @(negedge clk);
         while (entry_busy && n < 40) begin
            n++;
            if (irq_req) chk("R10 no req in busy", irq_req, 0);
            if (vec_load) begin
               seen = 1;
               chk("R11 load cycle", 8'(n), 12);
               chk("R11 step", vec_step, 4'h3);
               cpu_ie = 0;
            end
            @(negedge clk);
         end
         chk("R11 busy length", 8'(n), 12);
         chk("R11 strobe seen", seen, 1);
      end
      clear_all();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule